// File: doc/BRIEF.md
# Converter Serial-Port State Machine

This block is the device-side digital controller of a serial analog-to-digital converter. After power-up it starts a conversion on its own. When a conversion finishes, it stores the result and waits in a low-power state. The host then reads the stored result over a three-wire serial link: an active-low chip select, a host-driven serial clock, and one data line in each direction. The analog conversion is not part of the block. An internal cycle counter sets how long a conversion lasts. In the last cycle of that window the block samples the 16-bit result that the analog side presents.

During a readout the host shifts the result out, most significant bit first. At the same time it clocks in a 4-bit configuration word. That word selects the conversion speed and decides whether the reference is powered down after the next conversion. A readout ends on the sixteenth serial clock falling edge, or earlier if chip select rises. Either way a new conversion starts, and any newly written configuration becomes active at that moment. A supply-good flag that drops, or the synchronous reset, returns the block to a power-on hold. That hold clears all state and lasts a parameterised number of cycles.

Chip select, serial clock and serial input are synchronised into the system clock domain, and the serial clock edges are detected there. The serial clock must therefore run several times slower than the system clock.

Top module: `adc_serial_fsm`

## Requirements
- R1: While rst_n or supply_ok is low, sdo, conv_start, ref_pd, cfg_speed and cfg_sleep are all 0. After both are high, conv_start pulses for one cycle exactly POR_CYCLES clock edges later.
- R2: A conversion lasts CONV_CYCLES clock cycles when cfg_speed is 0 and 2*CONV_CYCLES cycles when cfg_speed is 1, counted from the conv_start pulse to the end of the conversion (visible as the ref_pd rise when cfg_sleep is 1).
- R3: A completed conversion stores conv_result as sampled in its last cycle. When cs_n is low after that, the block enters the readout state and sdo shows bit 15 of the stored result before the first sck rising edge.
- R4: Each sck falling edge in the readout state moves sdo to the next lower result bit. The sixteenth falling edge ends the readout and pulses conv_start.
- R5: A cs_n rising edge during the readout ends it at once, whatever the bit position, and pulses conv_start.
- R6: sdi is sampled on sck rising edges. The first bit is an enable that must be 1, the second an enable that must be 0, the third the speed bit and the fourth the sleep bit. Speed and sleep are stored as pending values only when both enable bits match.
- R7: A word with a non-matching enable pair, a readout aborted before the fourth sck rising edge, and any sdi bits after the fourth all leave the pending values unchanged.
- R8: cfg_speed and cfg_sleep take the pending values only in the cycle where conv_start is high, so they stay unchanged throughout a readout.
- R9: At the end of a conversion with cfg_sleep at 1 and cs_n high, ref_pd goes to 1. With cfg_sleep at 0, ref_pd stays 0.
- R10: ref_pd returns to 0 within a few cycles of cs_n going low.
- R11: sdo is 0 whenever the block is outside the readout state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| supply_ok | input | 1 | Supply-good flag; low holds the power-on clear |
| cs_n | input | 1 | Active-low chip select from the host |
| sck | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial configuration input |
| conv_result | input | 16 | Result presented by the analog side |
| sdo | output | 1 | Serial result output |
| conv_start | output | 1 | One-cycle pulse starting a conversion |
| ref_pd | output | 1 | Reference power-down control |
| cfg_speed | output | 1 | Active speed setting (1 = half rate) |
| cfg_sleep | output | 1 | Active sleep setting (1 = power down reference) |

## Verification
The bench builds the block with POR_CYCLES at 20 and CONV_CYCLES at 40 instead of the millisecond-scale defaults. This lets the power-on hold and both conversion lengths be counted edge by edge within a short run. With these values, the exact conv_start-to-ref_pd interval for both speed settings and a full supply-drop recovery fit next to seven readouts. Those readouts cover full, aborted and partially programmed frames. The serial clock phases last eight system cycles, which keeps them clear of the synchroniser delay.

// File: rtl/adc_sp_pkg.sv
// Package: shared types and constants for the converter serial-port block.
// Assumes: a single system clock domain; all host signals are asynchronous.
package adc_sp_pkg;
    // Top-level sequencing states.
    typedef enum logic [1:0] {
        ST_POR  = 2'd0,
        ST_CONV = 2'd1,
        ST_IDLE = 2'd2,
        ST_DATA = 2'd3
    } sp_state_e;

    // Length of the configuration word clocked in on sdi.
    localparam int CFG_WORD_BITS = 4;
endpackage

// File: rtl/sp_sync.sv
// Module: sp_sync
// Brings one asynchronous host pin into the clk domain through STAGES flops
// and exposes the last two synchronised samples for edge detection.
// Assumes: STAGES >= 2; the pin changes slower than a few clk periods.
module sp_sync #(
    parameter int STAGES = 2,
    parameter bit INIT   = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       din,
    output logic [1:0] hist
);
    logic [STAGES-1:0] pipe;
    logic              prev;

    // Shift the pin through the synchroniser chain.
    always_ff @(posedge clk) begin
        if (!rst_n) pipe <= {STAGES{INIT}};
        else        pipe <= {pipe[STAGES-2:0], din};
    end

    // Hold the previous synchronised sample for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= INIT;
        else        prev <= pipe[STAGES-1];
    end

    assign hist = {prev, pipe[STAGES-1]};
endmodule

// File: rtl/sp_cfg_capture.sv
// Module: sp_cfg_capture
// Collects the first CFG_WORD_BITS sdi bits of a readout on sck rising edges
// and updates the pending speed/sleep values when the enable pair matches.
// Assumes: sdi is synchronised with the same depth as sck so bits line up.
module sp_cfg_capture
    import adc_sp_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic frame_start,
    input  logic sck_rise,
    input  logic sdi,
    output logic pend_speed,
    output logic pend_sleep
);
    localparam int NB_W = $clog2(CFG_WORD_BITS + 1);

    logic [STAGES-1:0]        sdi_pipe;
    logic [CFG_WORD_BITS-2:0] word_sh;
    logic [NB_W-1:0]          nbits;
    logic                     sdi_s;
    logic [CFG_WORD_BITS-1:0] word;

    assign sdi_s = sdi_pipe[STAGES-1];
    assign word  = {word_sh, sdi_s};

    // Synchronise sdi alongside sck.
    always_ff @(posedge clk) begin
        if (!rst_n) sdi_pipe <= '0;
        else        sdi_pipe <= {sdi_pipe[STAGES-2:0], sdi};
    end

    // Shift in the word and decode it on its last bit.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_sh    <= '0;
            nbits      <= '0;
            pend_speed <= 1'b0;
            pend_sleep <= 1'b0;
        end else if (frame_start) begin
            nbits <= '0;
        end else if (sck_rise && nbits < NB_W'(CFG_WORD_BITS)) begin
            word_sh <= word[CFG_WORD_BITS-2:0];
            nbits   <= nbits + 1'b1;
            if (nbits == NB_W'(CFG_WORD_BITS - 1) &&
                word[CFG_WORD_BITS-1] && !word[CFG_WORD_BITS-2]) begin
                pend_speed <= word[1];
                pend_sleep <= word[0];
            end
        end
    end

    // R7: pending values never change once the word is complete.
    a_r7_ignore_late: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(nbits) == NB_W'(CFG_WORD_BITS) && nbits == NB_W'(CFG_WORD_BITS))
        |-> ($stable(pend_speed) && $stable(pend_sleep)));
endmodule

// File: rtl/sp_shift_out.sv
// Module: sp_shift_out
// Parallel-load, MSB-first output shifter for the conversion result; flags
// the shift that moves past the last bit.
// Assumes: load and shift are never high together.
module sp_shift_out #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [WIDTH-1:0] load_val,
    input  logic             shift,
    output logic             msb,
    output logic             last
);
    localparam int CW = $clog2(WIDTH);

    logic [WIDTH-1:0] sh;
    logic [CW-1:0]    cnt;

    // Load the result on frame entry and move it up on each falling edge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sh  <= '0;
            cnt <= '0;
        end else if (load) begin
            sh  <= load_val;
            cnt <= '0;
        end else if (shift) begin
            sh  <= {sh[WIDTH-2:0], 1'b0};
            cnt <= cnt + 1'b1;
        end
    end

    assign msb  = sh[WIDTH-1];
    assign last = shift && (cnt == CW'(WIDTH - 1));
endmodule

// File: rtl/adc_serial_fsm.sv
// Module: adc_serial_fsm (top)
// Sequences power-on hold, timed conversion, low-power wait and serial
// readout of a converter; applies host configuration at conversion start.
// Assumes: sck is at least ~6x slower than clk in each phase; conv_result is
// valid in the last cycle of a conversion.
module adc_serial_fsm
    import adc_sp_pkg::*;
#(
    parameter int POR_CYCLES  = 25000,
    parameter int CONV_CYCLES = 833333,
    parameter int DATA_BITS   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 supply_ok,
    input  logic                 cs_n,
    input  logic                 sck,
    input  logic                 sdi,
    input  logic [DATA_BITS-1:0] conv_result,
    output logic                 sdo,
    output logic                 conv_start,
    output logic                 ref_pd,
    output logic                 cfg_speed,
    output logic                 cfg_sleep
);
    localparam int TMAX  = (2 * CONV_CYCLES > POR_CYCLES) ? 2 * CONV_CYCLES : POR_CYCLES;
    localparam int CNT_W = $clog2(TMAX + 1);
    localparam logic [CNT_W-1:0] POR_LAST  = CNT_W'(POR_CYCLES - 1);
    localparam logic [CNT_W-1:0] FAST_LAST = CNT_W'(CONV_CYCLES - 1);
    localparam logic [CNT_W-1:0] SLOW_LAST = CNT_W'(2 * CONV_CYCLES - 1);

    sp_state_e            state;
    logic [CNT_W-1:0]     cnt;
    logic [DATA_BITS-1:0] result_q;
    logic                 core_rst_n;
    logic [1:0]           cs_hist, sck_hist;
    logic                 cs_lvl, cs_rise, sck_rise, sck_fall;
    logic                 frame_start, frame_done, sh_msb;
    logic                 pend_speed, pend_sleep;
    logic [CNT_W-1:0]     conv_last;

    assign core_rst_n = rst_n & supply_ok;

    sp_sync #(.STAGES(SYNC_STAGES), .INIT(1'b1)) u_cs_sync (
        .clk(clk), .rst_n(core_rst_n), .din(cs_n), .hist(cs_hist));
    sp_sync #(.STAGES(SYNC_STAGES), .INIT(1'b0)) u_sck_sync (
        .clk(clk), .rst_n(core_rst_n), .din(sck), .hist(sck_hist));

    assign cs_lvl   = cs_hist[0];
    assign cs_rise  = cs_hist[0] & ~cs_hist[1];
    assign sck_rise = sck_hist[0] & ~sck_hist[1];
    assign sck_fall = ~sck_hist[0] & sck_hist[1];

    assign frame_start = (state == ST_IDLE) && !cs_lvl;
    assign conv_last   = cfg_speed ? SLOW_LAST : FAST_LAST;

    sp_cfg_capture #(.STAGES(SYNC_STAGES)) u_cfg (
        .clk(clk), .rst_n(core_rst_n), .frame_start(frame_start),
        .sck_rise(sck_rise && state == ST_DATA), .sdi(sdi),
        .pend_speed(pend_speed), .pend_sleep(pend_sleep));

    sp_shift_out #(.WIDTH(DATA_BITS)) u_shift (
        .clk(clk), .rst_n(core_rst_n), .load(frame_start), .load_val(result_q),
        .shift(sck_fall && state == ST_DATA), .msb(sh_msb), .last(frame_done));

    assign sdo = (state == ST_DATA) && sh_msb;

    // Main sequencer: power-on hold, timed conversion, wait, readout.
    always_ff @(posedge clk) begin
        if (!core_rst_n) begin
            state      <= ST_POR;
            cnt        <= '0;
            conv_start <= 1'b0;
            ref_pd     <= 1'b0;
            cfg_speed  <= 1'b0;
            cfg_sleep  <= 1'b0;
            result_q   <= '0;
        end else begin
            conv_start <= 1'b0;
            if (!cs_lvl) ref_pd <= 1'b0;
            case (state)
                ST_POR: begin
                    if (cnt == POR_LAST) begin
                        state      <= ST_CONV;
                        cnt        <= '0;
                        conv_start <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_CONV: begin
                    if (cnt == conv_last) begin
                        state    <= ST_IDLE;
                        cnt      <= '0;
                        result_q <= conv_result;
                        if (cfg_sleep && cs_lvl) ref_pd <= 1'b1;
                    end else begin
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_IDLE: begin
                    if (!cs_lvl) state <= ST_DATA;
                end
                ST_DATA: begin
                    if (cs_rise || frame_done) begin
                        state      <= ST_CONV;
                        cnt        <= '0;
                        conv_start <= 1'b1;
                        cfg_speed  <= pend_speed;
                        cfg_sleep  <= pend_sleep;
                    end
                end
                default: state <= ST_POR;
            endcase
        end
    end

    // R1: the start strobe lasts a single cycle.
    a_r1_start_pulse: assert property (@(posedge clk) disable iff (!core_rst_n)
        conv_start |=> !conv_start);

    // R8: active configuration moves only with a conversion start or a clear.
    a_r8_cfg_at_start: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable({cfg_speed, cfg_sleep}) |-> (conv_start || !$past(supply_ok)));

    // R9: reference power-down only follows a conversion in sleep mode.
    a_r9_pd_needs_sleep: assert property (@(posedge clk) disable iff (!core_rst_n)
        $rose(ref_pd) |-> (cfg_sleep && $past(state) == ST_CONV));

    // R10: a low chip select releases the reference on the next edge.
    a_r10_pd_release: assert property (@(posedge clk) disable iff (!core_rst_n)
        !cs_lvl |=> !ref_pd);

    // R4: within a readout sdo moves only after a detected falling edge.
    a_r4_sdo_hold: assert property (@(posedge clk) disable iff (!core_rst_n)
        (state == ST_DATA && $past(state) == ST_DATA && !$past(sck_fall))
        |-> $stable(sdo));
endmodule

// File: tb/sim_adc_serial_fsm.sv
module sim_adc_serial_fsm;
    localparam int POR_C  = 20;
    localparam int CONV_C = 40;

    // Vector: {result[15:0], cfg word[3:0] (first bit sent = bit 3), falls[4:0]}
    localparam logic [24:0] VEC [7] = '{
        {16'hA5C3, 4'b1010, 5'd16},
        {16'h3C5A, 4'b1001, 5'd16},
        {16'hFFFF, 4'b1111, 5'd16},
        {16'h0001, 4'b1011, 5'd3},
        {16'h5555, 4'b1000, 5'd7},
        {16'h8000, 4'b1011, 5'd16},
        {16'h1234, 4'b0110, 5'd16}
    };

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic rst_n, supply_ok, cs_n, sck, sdi;
    logic [15:0] conv_result;
    logic sdo, conv_start, ref_pd, cfg_speed, cfg_sleep;

    adc_serial_fsm #(.POR_CYCLES(POR_C), .CONV_CYCLES(CONV_C)) u0 (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .cs_n(cs_n),
        .sck(sck), .sdi(sdi), .conv_result(conv_result), .sdo(sdo),
        .conv_start(conv_start), .ref_pd(ref_pd), .cfg_speed(cfg_speed),
        .cfg_sleep(cfg_sleep));

    int checks = 0, errors = 0;
    int cyc = 0, starts = 0, t_start = 0, t_pd = 0;
    logic pd_d = 1'b0;

    // Event log: count start pulses and stamp start and ref_pd rise.
    always @(posedge clk) begin
        cyc  <= cyc + 1;
        pd_d <= ref_pd;
        if (conv_start) begin
            starts  <= starts + 1;
            t_start <= cyc;
        end
        if (ref_pd && !pd_d) t_pd <= cyc;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clocks(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual hung expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    logic m_speed, m_sleep, p_speed, p_sleep;
    int n, len, s0, mism;
    logic [15:0] res;
    logic [3:0]  w;
    int nf;

    initial begin
        rst_n = 0; supply_ok = 1; cs_n = 1; sck = 0; sdi = 0; conv_result = '0;
        m_speed = 0; m_sleep = 0; p_speed = 0; p_sleep = 0;
        clocks(4);
        chk("R1 reset outputs", {sdo, conv_start, ref_pd, cfg_speed, cfg_sleep}, 0);
        rst_n = 1;
        n = 0;
        do begin @(negedge clk); n++; end while (!conv_start && n < 1000);
        chk("R1 por length", n, POR_C);
        conv_result = VEC[0][24:9];

        for (int k = 0; k < 7; k++) begin
            res = VEC[k][24:9]; w = VEC[k][8:5]; nf = int'(VEC[k][4:0]);
            len = m_speed ? 2 * CONV_C : CONV_C;
            clocks(len + 6);
            chk("R9 ref_pd after conversion", ref_pd, m_sleep);
            if (m_sleep) chk("R2 conversion length", t_pd - t_start, len);
            chk("R11 sdo idle", sdo, 0);
            s0 = starts;
            cs_n = 0;
            clocks(10);
            chk("R10 ref release", ref_pd, 0);
            mism = 0;
            for (int i = 0; i < nf; i++) begin
                sdi = (i < 4) ? w[3 - i] : logic'(i % 2);
                clocks(6);
                if (i == 0) chk("R3 first bit", sdo, res[15]);
                else if (sdo !== res[15 - i]) mism++;
                if (i == 4) chk("R8 cfg held in frame", {cfg_speed, cfg_sleep}, {m_speed, m_sleep});
                sck = 1; clocks(8);
                sck = 0; clocks(8);
            end
            chk("R4 bit sequence", mism, 0);
            if (nf == 16) begin
                chk("R4 start after 16th fall", starts, s0 + 1);
                cs_n = 1; clocks(2);
            end else begin
                chk("R5 no start before abort", starts, s0);
                cs_n = 1; clocks(8);
                chk("R5 abort start", starts, s0 + 1);
            end
            if (nf >= 4 && w[3:2] == 2'b10) begin
                p_speed = w[1]; p_sleep = w[0];
            end
            m_speed = p_speed; m_sleep = p_sleep;
            if (nf >= 4 && w[3:2] == 2'b10)
                chk("R6 cfg applied", {cfg_speed, cfg_sleep}, {m_speed, m_sleep});
            else
                chk("R7 cfg kept", {cfg_speed, cfg_sleep}, {m_speed, m_sleep});
            chk("R11 sdo after frame", sdo, 0);
            conv_result = (k < 6) ? VEC[k + 1][24:9] : 16'h0;
        end

        len = m_speed ? 2 * CONV_C : CONV_C;
        clocks(len + 6);
        chk("R9 final sleep", ref_pd, m_sleep);
        chk("R2 slow length", t_pd - t_start, len);
        supply_ok = 0;
        clocks(3);
        chk("R1 supply drop clears", {sdo, conv_start, ref_pd, cfg_speed, cfg_sleep}, 0);
        supply_ok = 1;
        n = 0;
        do begin @(negedge clk); n++; end while (!conv_start && n < 1000);
        chk("R1 por after supply", n, POR_C);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule